// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This block carries out the operate class of a 12-bit accumulator machine. An operate word packs several micro-operations into one instruction: clearing, complementing and incrementing the accumulator (AC) and its one-bit carry (the link), rotating the 13-bit ring formed by link and AC, swapping the two 6-bit halves of AC, testing AC and link to decide whether the next instruction is skipped, merging a 12-bit switch register into AC, and requesting a halt. The micro-operations inside one word run in a fixed order, so a single word such as complement-then-increment gives a two's-complement negation.

The sequencer presents the instruction word, the current AC, link and switch register together with a one-cycle execute strobe. The unit evaluates the word combinationally and captures the new AC, new link, the skip flag, the halt request and an unsupported-word flag in registers. The sequencer then uses the skip flag to advance its program counter and writes the AC and link back. Words that are not of the operate class, and second-group words with the low bit set, are reported as unsupported and leave AC and link as they were presented.

Top module: `opr_exec_unit`

## Requirements
- R1: A word is of the operate class when bits 11:9 are 111 (octal 7xxx); bit 8 (octal 0400) clear selects group 1 and set selects group 2. Any word whose bits 11:9 are not 111 raises unsup_o, returns AC and link unchanged, and clears skip_o and halt_o.
- R2: In group 1, bit 7 (0200) clears AC and bit 6 (0100) clears the link first; bit 5 (0040) complements AC and bit 4 (0020) complements the link after that, so 7240 gives AC = 7777 and 7120 gives link = 1.
- R3: In group 1, bit 0 (0001) adds one to AC after clear and complement; a carry out of AC toggles the link. 7041 yields the two's-complement negation of AC, and incrementing 7777 gives 0000 with the link toggled.
- R4: In group 1, bit 3 (0010) rotates the 13-bit ring {link, AC} right by one and bit 2 (0004) rotates it left by one, after clear, complement and increment; with both bits set no rotation or swap takes place.
- R5: In group 1, bit 1 (0002) together with exactly one rotate bit makes the rotation two places (7012 two right, 7006 two left).
- R6: In group 1, bit 1 with neither rotate bit set swaps AC[11:6] and AC[5:0] as the last step, leaving the link unchanged (7002 turns 1234 into 3412).
- R7: A group 1 word never sets skip_o or halt_o.
- R8: In group 2 with bit 3 (0010) clear, bit 6 (0100) tests AC negative (AC[11] = 1), bit 5 (0040) tests AC zero and bit 4 (0020) tests link = 1; skip_o is set if any selected test is true.
- R9: In group 2 with bit 3 set, bits 6, 5 and 4 test AC non-negative, AC non-zero and link = 0; skip_o is set only if every selected test is true, so 7410 always skips.
- R10: In group 2 the skip tests use AC as presented; then bit 7 (0200) clears AC and then bit 2 (0004) ORs the switch register into AC; the link is returned unchanged.
- R11: In group 2, bit 1 (0002) sets halt_o, and the skip result of the same word is still reported.
- R12: A group 2 word with bit 0 (0001) set raises unsup_o, returns AC and link unchanged and clears skip_o and halt_o.
- R13: Results appear on the outputs on the clock edge that samples exec_i high, with valid_o high for that one following cycle; without exec_i the outputs hold their values whatever the other inputs do; reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe, one cycle per word |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link |
| sw_i | input | 12 | Switch register |
| acc_o | output | 12 | Registered next accumulator |
| link_o | output | 1 | Registered next link |
| skip_o | output | 1 | Registered skip-next-instruction flag |
| halt_o | output | 1 | Registered halt request |
| unsup_o | output | 1 | Registered unsupported-word flag |
| valid_o | output | 1 | High for one cycle when new results are on the outputs |

## Verification
Every result of a word is due exactly one clock edge after the edge that samples exec_i, all of them together and flagged by valid_o. The driver pushes the expected AC, link, skip, halt and unsupported flag for each word as it raises exec_i on a falling edge, and the monitor pops and compares on the next falling edge where valid_o is high, so each comparison lands half a cycle after the registers load. Hold behaviour is checked a few cycles after the strobe drops, with the data inputs changed in between.

// File: rtl/opr_pkg.sv
package opr_pkg;

  localparam int unsigned OPR_W  = 12;
  localparam int unsigned HALF_W = OPR_W / 2;
  localparam int unsigned RING_W = OPR_W + 1;

  // Ring layout: bit OPR_W is the link, bits OPR_W-1:0 are AC.
  function automatic logic [RING_W-1:0] ring_rot_right(input logic [RING_W-1:0] r);
    return (r >> 1) | (r << (RING_W - 1));
  endfunction

  function automatic logic [RING_W-1:0] ring_rot_left(input logic [RING_W-1:0] r);
    return (r << 1) | (r >> (RING_W - 1));
  endfunction

  function automatic logic [OPR_W-1:0] half_swap(input logic [OPR_W-1:0] a);
    return {a[HALF_W-1:0], a[OPR_W-1:HALF_W]};
  endfunction

  // sel = {negative test, zero test, link test}; returns the OR of the
  // selected raw conditions.
  function automatic logic cond_any(input logic [2:0] sel,
                                    input logic [OPR_W-1:0] a,
                                    input logic l);
    return (sel[2] & a[OPR_W-1]) | (sel[1] & (a == '0)) | (sel[0] & l);
  endfunction

endpackage

// File: rtl/opr_grp1.sv
module opr_grp1
  import opr_pkg::*;
(
  input  logic [7:0]       op_i,
  input  logic [OPR_W-1:0] acc_i,
  input  logic             link_i,
  output logic [OPR_W-1:0] acc_o,
  output logic             link_o,
  output logic             inc_carry_o
);

  localparam int unsigned B_CLA = 7;
  localparam int unsigned B_CLL = 6;
  localparam int unsigned B_CMA = 5;
  localparam int unsigned B_CML = 4;
  localparam int unsigned B_RAR = 3;
  localparam int unsigned B_RAL = 2;
  localparam int unsigned B_TWO = 1;
  localparam int unsigned B_IAC = 0;

  logic [OPR_W-1:0]  a_clr, a_cmp, a_inc;
  logic              l_clr, l_cmp, l_inc, carry;
  logic [RING_W-1:0] ring_in, ring_once, ring_out;

  // step 1 and 2: clear, then complement
  always_comb begin
    a_clr = op_i[B_CLA] ? '0 : acc_i;
    l_clr = op_i[B_CLL] ? 1'b0 : link_i;
    a_cmp = op_i[B_CMA] ? ~a_clr : a_clr;
    l_cmp = op_i[B_CML] ? ~l_clr : l_clr;
  end

  // step 3: increment, carry toggles the link
  always_comb begin
    {carry, a_inc} = {1'b0, a_cmp} + {{OPR_W{1'b0}}, op_i[B_IAC]};
    l_inc          = l_cmp ^ carry;
  end

  assign ring_in = {l_inc, a_inc};

  // step 4: rotate one or two places, or swap halves
  always_comb begin
    ring_once = ring_in;
    ring_out  = ring_in;
    unique case ({op_i[B_RAR], op_i[B_RAL]})
      2'b10: begin
        ring_once = ring_rot_right(ring_in);
        ring_out  = op_i[B_TWO] ? ring_rot_right(ring_once) : ring_once;
      end
      2'b01: begin
        ring_once = ring_rot_left(ring_in);
        ring_out  = op_i[B_TWO] ? ring_rot_left(ring_once) : ring_once;
      end
      2'b00: begin
        if (op_i[B_TWO]) ring_out = {l_inc, half_swap(a_inc)};
      end
      default: ring_out = ring_in;
    endcase
  end

  assign acc_o       = ring_out[OPR_W-1:0];
  assign link_o      = ring_out[OPR_W];
  assign inc_carry_o = carry;

endmodule

// File: rtl/opr_grp2.sv
module opr_grp2
  import opr_pkg::*;
(
  input  logic [7:1]       op_i,
  input  logic [OPR_W-1:0] acc_i,
  input  logic             link_i,
  input  logic [OPR_W-1:0] sw_i,
  output logic [OPR_W-1:0] acc_o,
  output logic             skip_o,
  output logic             halt_o,
  output logic             any_hit_o
);

  localparam int unsigned B_CLA = 7;
  localparam int unsigned B_SENSE = 3;
  localparam int unsigned B_OSR = 2;
  localparam int unsigned B_HLT = 1;

  logic [2:0]       sel;
  logic             hit;
  logic [OPR_W-1:0] a_clr;

  assign sel = op_i[6:4];

  // tests see AC as presented
  assign hit    = cond_any(sel, acc_i, link_i);
  assign skip_o = op_i[B_SENSE] ? ~hit : hit;

  // clear, then merge switches
  assign a_clr  = op_i[B_CLA] ? '0 : acc_i;
  assign acc_o  = op_i[B_OSR] ? (a_clr | sw_i) : a_clr;

  assign halt_o    = op_i[B_HLT];
  assign any_hit_o = hit;

endmodule

// File: rtl/opr_exec_unit.sv
module opr_exec_unit
  import opr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic [OPR_W-1:0] instr_i,
  input  logic [OPR_W-1:0] acc_i,
  input  logic             link_i,
  input  logic [OPR_W-1:0] sw_i,
  output logic [OPR_W-1:0] acc_o,
  output logic             link_o,
  output logic             skip_o,
  output logic             halt_o,
  output logic             unsup_o,
  output logic             valid_o
);

  localparam logic [2:0] OPR_CLASS = 3'b111;
  localparam int unsigned B_GRP = 8;

  // decode events, named for the checker
  logic is_opr, g1_sel, g2_sel, bad_sel;

  assign is_opr  = (instr_i[OPR_W-1:OPR_W-3] == OPR_CLASS);
  assign g1_sel  = is_opr & ~instr_i[B_GRP];
  assign g2_sel  = is_opr &  instr_i[B_GRP] & ~instr_i[0];
  assign bad_sel = ~(g1_sel | g2_sel);

  logic [OPR_W-1:0] g1_acc, g2_acc;
  logic             g1_link, g1_carry;
  logic             g2_skip, g2_halt, g2_hit;

  opr_grp1 u_grp1 (
    .op_i        (instr_i[7:0]),
    .acc_i       (acc_i),
    .link_i      (link_i),
    .acc_o       (g1_acc),
    .link_o      (g1_link),
    .inc_carry_o (g1_carry)
  );

  opr_grp2 u_grp2 (
    .op_i      (instr_i[7:1]),
    .acc_i     (acc_i),
    .link_i    (link_i),
    .sw_i      (sw_i),
    .acc_o     (g2_acc),
    .skip_o    (g2_skip),
    .halt_o    (g2_halt),
    .any_hit_o (g2_hit)
  );

  logic [OPR_W-1:0] nxt_acc;
  logic             nxt_link, nxt_skip, nxt_halt;

  always_comb begin
    nxt_acc  = acc_i;
    nxt_link = link_i;
    nxt_skip = 1'b0;
    nxt_halt = 1'b0;
    if (g1_sel) begin
      nxt_acc  = g1_acc;
      nxt_link = g1_link;
    end else if (g2_sel) begin
      nxt_acc  = g2_acc;
      nxt_skip = g2_skip;
      nxt_halt = g2_halt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o   <= '0;
      link_o  <= 1'b0;
      skip_o  <= 1'b0;
      halt_o  <= 1'b0;
      unsup_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= exec_i;
      if (exec_i) begin
        acc_o   <= nxt_acc;
        link_o  <= nxt_link;
        skip_o  <= nxt_skip;
        halt_o  <= nxt_halt;
        unsup_o <= bad_sel;
      end
    end
  end

endmodule

// File: rtl/opr_exec_chk.sv
module opr_exec_chk
  import opr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             exec_i,
  input logic [OPR_W-1:0] instr_i,
  input logic [OPR_W-1:0] acc_i,
  input logic             link_i,
  input logic [OPR_W-1:0] acc_o,
  input logic             link_o,
  input logic             skip_o,
  input logic             halt_o,
  input logic             unsup_o,
  input logic             valid_o,
  input logic             g1_sel,
  input logic             g2_sel,
  input logic             bad_sel,
  input logic             g1_carry,
  input logic             g2_hit
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(exec_i)); // R13

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(acc_o) && $stable(link_o) && $stable(skip_o) && $stable(halt_o)); // R13

  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({g1_sel, g2_sel, bad_sel})); // R1

  AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && bad_sel |=> unsup_o && acc_o == $past(acc_i) && link_o == $past(link_i)
                          && !skip_o && !halt_o); // R12

  AST_G1_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && g1_sel |=> !skip_o && !halt_o && !unsup_o); // R7

  AST_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && instr_i == 12'o7041 |=> acc_o == OPR_W'(0 - $past(acc_i))); // R3

  AST_CARRY_ONLY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && g1_sel && instr_i[7:4] == 4'b0000 && g1_carry |-> acc_i == '1); // R3

  AST_G2_LINK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && g2_sel |=> link_o == $past(link_i)); // R10

  AST_HALT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && g2_sel |=> halt_o == $past(instr_i[1])); // R11

  AST_SKP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && instr_i == 12'o7410 |=> skip_o); // R9

  AST_OR_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && g2_sel && !instr_i[3] |=> skip_o == $past(g2_hit)); // R8

endmodule

bind opr_exec_unit opr_exec_chk u_opr_exec_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exec_i   (exec_i),
  .instr_i  (instr_i),
  .acc_i    (acc_i),
  .link_i   (link_i),
  .acc_o    (acc_o),
  .link_o   (link_o),
  .skip_o   (skip_o),
  .halt_o   (halt_o),
  .unsup_o  (unsup_o),
  .valid_o  (valid_o),
  .g1_sel   (g1_sel),
  .g2_sel   (g2_sel),
  .bad_sel  (bad_sel),
  .g1_carry (g1_carry),
  .g2_hit   (g2_hit)
);

// File: tb/tb_opr_exec_unit.sv
module tb_opr_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [11:0] acc_i = '0;
  logic        link_i = 1'b0;
  logic [11:0] sw_i = '0;
  logic [11:0] acc_o;
  logic        link_o, skip_o, halt_o, unsup_o, valid_o;

  always #4 clk = ~clk; // 125 MHz

  opr_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i),
    .acc_i(acc_i), .link_i(link_i), .sw_i(sw_i),
    .acc_o(acc_o), .link_o(link_o), .skip_o(skip_o), .halt_o(halt_o),
    .unsup_o(unsup_o), .valid_o(valid_o)
  );

  typedef struct {
    logic [11:0] acc;
    logic        link;
    logic        skip;
    logic        halt;
    logic        unsup;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  // Behavioural model written from the requirements.
  function automatic exp_t model(input logic [11:0] ins, input logic [11:0] ac,
                                 input logic l, input logic [11:0] sw, input string tag);
    exp_t e;
    logic [12:0] r;
    bit neg, zer;
    e.acc = ac; e.link = l; e.skip = 0; e.halt = 0; e.unsup = 0; e.tag = tag;
    if (ins[11:9] != 3'b111) begin
      e.unsup = 1;
    end else if (!ins[8]) begin
      if (ins[7]) ac = 12'o0000;
      if (ins[6]) l = 1'b0;
      if (ins[5]) ac = ac ^ 12'o7777;
      if (ins[4]) l = !l;
      if (ins[0]) begin
        if (ac == 12'o7777) l = !l;
        ac = ac + 12'd1;
      end
      r = {l, ac};
      if (ins[3] && !ins[2]) begin
        r = {r[0], r[12:1]};
        if (ins[1]) r = {r[0], r[12:1]};
      end else if (ins[2] && !ins[3]) begin
        r = {r[11:0], r[12]};
        if (ins[1]) r = {r[11:0], r[12]};
      end else if (!ins[3] && !ins[2] && ins[1]) begin
        r = {r[12], r[5:0], r[11:6]};
      end
      e.link = r[12];
      e.acc  = r[11:0];
    end else if (ins[0]) begin
      e.unsup = 1;
    end else begin
      neg = ac[11];
      zer = (ac == 12'o0000);
      if (!ins[3])
        e.skip = (ins[6] && neg) || (ins[5] && zer) || (ins[4] && l);
      else
        e.skip = (!ins[6] || !neg) && (!ins[5] || !zer) && (!ins[4] || !l);
      e.acc  = (ins[7] ? 12'o0000 : ac) | (ins[2] ? sw : 12'o0000);
      e.halt = ins[1];
    end
    return e;
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %o expected %o", tag, what, act, exp);
    end
  endtask

  // driver: one word per call, strobe stays high for back-to-back calls
  task automatic run(input logic [11:0] ins, input logic [11:0] ac,
                     input logic l, input logic [11:0] sw, input string tag);
    exp_t e;
    @(negedge clk);
    instr_i = ins; acc_i = ac; link_i = l; sw_i = sw; exec_i = 1'b1;
    e = model(ins, ac, l, sw, tag);
    q.push_back(e);
    last_exp = e;
  endtask

  // monitor: compares half a cycle after the capturing edge
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13 unexpected valid_o actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check_eq(e.tag, "acc",   acc_o,           e.acc);
        check_eq(e.tag, "link",  {11'd0, link_o},  {11'd0, e.link});
        check_eq(e.tag, "skip",  {11'd0, skip_o},  {11'd0, e.skip});
        check_eq(e.tag, "halt",  {11'd0, halt_o},  {11'd0, e.halt});
        check_eq(e.tag, "unsup", {11'd0, unsup_o}, {11'd0, e.unsup});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle_hold(input string tag);
    @(negedge clk);
    exec_i = 1'b0;
    @(negedge clk);
    instr_i = 12'o7200; acc_i = 12'o5555; link_i = ~link_i; sw_i = 12'o7777;
    repeat (3) @(negedge clk);
    check_eq(tag, "hold acc",   acc_o,           last_exp.acc);
    check_eq(tag, "hold link",  {11'd0, link_o},  {11'd0, last_exp.link});
    check_eq(tag, "hold skip",  {11'd0, skip_o},  {11'd0, last_exp.skip});
    check_eq(tag, "hold halt",  {11'd0, halt_o},  {11'd0, last_exp.halt});
    check_eq(tag, "hold valid", {11'd0, valid_o}, 12'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R13", "reset acc", acc_o, 12'o0000);
    check_eq("R13", "reset flags", {7'd0, link_o, skip_o, halt_o, unsup_o, valid_o}, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R13", "after reset acc", acc_o, 12'o0000);

    // R1 class and group selection
    run(12'o1234, 12'o4321, 1'b1, 12'o0, "R1");
    run(12'o6201, 12'o0007, 1'b0, 12'o0, "R1");
    // R2 clear then complement
    run(12'o7200, 12'o1234, 1'b1, 12'o0, "R2");
    run(12'o7300, 12'o1234, 1'b1, 12'o0, "R2");
    run(12'o7240, 12'o1234, 1'b0, 12'o0, "R2");
    run(12'o7120, 12'o0000, 1'b1, 12'o0, "R2");
    // R3 increment and carry
    run(12'o7041, 12'o0005, 1'b0, 12'o0, "R3");
    run(12'o7041, 12'o0000, 1'b0, 12'o0, "R3");
    run(12'o7001, 12'o7777, 1'b1, 12'o0, "R3");
    // R4 single rotate, both bits
    run(12'o7010, 12'o0001, 1'b0, 12'o0, "R4");
    run(12'o7004, 12'o4000, 1'b0, 12'o0, "R4");
    run(12'o7014, 12'o1234, 1'b1, 12'o0, "R4");
    run(12'o7016, 12'o1234, 1'b0, 12'o0, "R4");
    // R5 double rotate
    run(12'o7012, 12'o0003, 1'b0, 12'o0, "R5");
    run(12'o7006, 12'o6000, 1'b0, 12'o0, "R5");
    // R6 byte swap
    run(12'o7002, 12'o1234, 1'b1, 12'o0, "R6");
    run(12'o7003, 12'o0077, 1'b0, 12'o0, "R6");
    // R7 group 1 never skips
    run(12'o7777 & 12'o7377, 12'o4000, 1'b1, 12'o0, "R7");
    // R8 OR sense
    run(12'o7500, 12'o4000, 1'b0, 12'o0, "R8");
    run(12'o7500, 12'o0100, 1'b0, 12'o0, "R8");
    run(12'o7460, 12'o0005, 1'b1, 12'o0, "R8");
    run(12'o7440, 12'o0005, 1'b0, 12'o0, "R8");
    // R9 AND sense
    run(12'o7510, 12'o0100, 1'b0, 12'o0, "R9");
    run(12'o7550, 12'o0000, 1'b0, 12'o0, "R9");
    run(12'o7530, 12'o0001, 1'b0, 12'o0, "R9");
    run(12'o7530, 12'o0001, 1'b1, 12'o0, "R9");
    run(12'o7410, 12'o4000, 1'b1, 12'o0, "R9");
    // R10 tests before clear, clear before OR
    run(12'o7640, 12'o0000, 1'b1, 12'o0, "R10");
    run(12'o7604, 12'o1234, 1'b0, 12'o0070, "R10");
    run(12'o7404, 12'o1200, 1'b1, 12'o0034, "R10");
    // R11 halt with skip
    run(12'o7402, 12'o0012, 1'b0, 12'o0, "R11");
    run(12'o7442, 12'o0000, 1'b0, 12'o0, "R11");
    // R12 group 2 low bit
    run(12'o7401, 12'o3333, 1'b1, 12'o0, "R12");
    run(12'o7601, 12'o2222, 1'b0, 12'o0, "R12");
    idle_hold("R13");

    // sweep of the whole operate space against the model
    for (int i = 0; i < 512; i++) begin
      run(12'o7000 | 12'(i), 12'((i * 37) ^ (i << 5)), i[0] ^ i[3], 12'(i * 11), "R1");
    end
    idle_hold("R13");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R13 pending results actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule